// File: doc/BRIEF.md
# Readout ADC Clock and Debug Observation Mux

This block drives the sampling clock for an external ADC that digitises the analog column outputs of a pixel matrix. It also selects one of four internal control signals for a single debug pin. Row control runs in frames of a fixed number of main-clock cycles, and a per-row command strobe marks the start of each frame. During the readout phase every frame reads one stored cell, and the ADC clock gives two pulses inside that frame. The first pulse samples the precharge reference level and the second samples the cell level. Each pulse is placed after the analog line has had a cycle to settle. During the write phase the ADC clock stays low. Both pixel types use the same ADC clock.

The debug pin shows one internal signal, chosen by a 2-bit select. The choices are the read select of the last row stage, the sampled clock select, the sampled cell-0 select of standard rows and the sampled cell-0 select of clamping rows. The debug output is registered, so a change of select cannot glitch the pin.

Top module: `readout_adcclk_dbg`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `adc_clk` and `dbg_out` are 0.
- R2: A strobe sampled with `rd_phase` high at clock edge E0 starts a frame of FRAME_LEN cycles. `adc_clk` is high only in the cycle after edge E(REF_SLOT+1), which is the reference sample, and in the cycle after edge E(CELL_SLOT+1), which is the cell sample. That gives exactly two rising edges per frame. The defaults 1 and 3 put the pulses after E2 and E4.
- R3: If `rd_phase` is low at an edge, `adc_clk` is 0 after the next edge. A frame started during the write phase gives no ADC edges.
- R4: Four back-to-back readout frames, one per stored cell of a four-cell pixel, give exactly eight rising edges of `adc_clk`.
- R5: If `rd_phase` drops in the middle of a readout frame, the pulses still pending in that frame are suppressed.
- R6: When a frame has ended and no new strobe arrives, `adc_clk` stays 0.
- R7: A strobe that arrives during a running frame restarts the frame at position 0, and the pulse timing of R2 is counted from that strobe.
- R8: `dbg_out` follows `dbg_sel` as follows: 0 gives `obs_last_row_rd`, 1 gives `obs_clk_sel`, 2 gives `obs_cell0_sel` and 3 gives `obs_clamp_cell0_sel`.
- R9: `dbg_out` changes only at a clock edge. It shows the value selected at that edge, so a select change between edges has no effect on the pin until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_phase | input | 1 | High during the readout phase, low during the write phase |
| frame_stb | input | 1 | One-cycle strobe at the start of each row frame |
| obs_last_row_rd | input | 1 | Read select of the last row stage |
| obs_clk_sel | input | 1 | Sampled clock select |
| obs_cell0_sel | input | 1 | Sampled cell-0 select, standard rows |
| obs_clamp_cell0_sel | input | 1 | Sampled cell-0 select, clamping rows |
| dbg_sel | input | 2 | Debug source select |
| adc_clk | output | 1 | ADC sampling clock |
| dbg_out | output | 1 | Registered debug observation output |

## Verification
The bench uses the default parameters: a frame of 6 cycles with the reference slot at 1 and the cell slot at 3. With these values a whole frame, a pixel of four frames and a restart in mid-frame each take only a handful of cycles. Expected pulse positions come from the slot parameters, so a pulse one cycle off or a missing gap between the two pulses shows up directly. Frames that run back to back exercise the hand-over at the frame boundary, where the count of the old frame ends in the same cycle as the new strobe arrives.

// File: rtl/readout_adcclk_pkg.sv
package readout_adcclk_pkg;
  typedef enum logic [1:0] {
    DBG_LAST_ROW_RD   = 2'd0,
    DBG_CLK_SEL       = 2'd1,
    DBG_CELL0_SEL     = 2'd2,
    DBG_CLAMP_CELL0   = 2'd3
  } dbg_src_e;

  localparam int DBG_SOURCES = 4;

  function automatic int cnt_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/rof_frame_timer.sv
module rof_frame_timer #(
  parameter int FRAME_LEN = 6,
  localparam int CNT_W = readout_adcclk_pkg::cnt_bits(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_stb,
  output logic [CNT_W-1:0] pos,
  output logic             active
);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_LEN - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos    <= '0;
      active <= 1'b0;
    end else if (frame_stb) begin
      pos    <= '0;
      active <= 1'b1;
    end else if (active) begin
      if (pos == LAST_POS) begin
        active <= 1'b0;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  AST_POS_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    pos <= LAST_POS); // R2

  AST_STROBE_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    frame_stb |=> (pos == '0) && active); // R7
endmodule

// File: rtl/rof_adc_pulse.sv
module rof_adc_pulse #(
  parameter int FRAME_LEN = 6,
  parameter int REF_SLOT  = 1,
  parameter int CELL_SLOT = 3,
  localparam int CNT_W = readout_adcclk_pkg::cnt_bits(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_phase,
  input  logic             active,
  input  logic [CNT_W-1:0] pos,
  output logic             adc_clk
);
  localparam logic [CNT_W-1:0] REF_POS  = CNT_W'(REF_SLOT);
  localparam logic [CNT_W-1:0] CELL_POS = CNT_W'(CELL_SLOT);

  logic slot_hit;
  always_comb slot_hit = (pos == REF_POS) || (pos == CELL_POS);

  always_ff @(posedge clk) begin
    if (rst) adc_clk <= 1'b0;
    else     adc_clk <= active && rd_phase && slot_hit;
  end

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    adc_clk |=> !adc_clk); // R2
endmodule

// File: rtl/rof_dbg_mux.sv
module rof_dbg_mux #(
  parameter int N_SRC = readout_adcclk_pkg::DBG_SOURCES,
  localparam int SEL_W = readout_adcclk_pkg::cnt_bits(N_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src,
  input  logic [SEL_W-1:0] sel,
  output logic             dbg_out
);
  logic pick;
  always_comb begin
    pick = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (sel == SEL_W'(i)) pick = src[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dbg_out <= 1'b0;
    else     dbg_out <= pick;
  end

  AST_DBG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && sel == $past(sel) && src == $past(src)) |=> $stable(dbg_out)); // R9
endmodule

// File: rtl/readout_adcclk_dbg.sv
module readout_adcclk_dbg #(
  parameter int FRAME_LEN = 6,
  parameter int REF_SLOT  = 1,
  parameter int CELL_SLOT = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_phase,
  input  logic       frame_stb,
  input  logic       obs_last_row_rd,
  input  logic       obs_clk_sel,
  input  logic       obs_cell0_sel,
  input  logic       obs_clamp_cell0_sel,
  input  logic [1:0] dbg_sel,
  output logic       adc_clk,
  output logic       dbg_out
);
  import readout_adcclk_pkg::*;
  localparam int CNT_W = cnt_bits(FRAME_LEN);

  logic [CNT_W-1:0]       pos;
  logic                   active;
  logic [DBG_SOURCES-1:0] src;

  rof_frame_timer #(.FRAME_LEN(FRAME_LEN)) u_timer (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .pos(pos), .active(active)
  );

  rof_adc_pulse #(.FRAME_LEN(FRAME_LEN), .REF_SLOT(REF_SLOT), .CELL_SLOT(CELL_SLOT)) u_pulse (
    .clk(clk), .rst(rst), .rd_phase(rd_phase), .active(active), .pos(pos), .adc_clk(adc_clk)
  );

  always_comb begin
    src = '0;
    src[DBG_LAST_ROW_RD] = obs_last_row_rd;
    src[DBG_CLK_SEL]     = obs_clk_sel;
    src[DBG_CELL0_SEL]   = obs_cell0_sel;
    src[DBG_CLAMP_CELL0] = obs_clamp_cell0_sel;
  end

  rof_dbg_mux #(.N_SRC(DBG_SOURCES)) u_dbg (
    .clk(clk), .rst(rst), .src(src), .sel(dbg_sel), .dbg_out(dbg_out)
  );

  AST_WRITE_PHASE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rd_phase |=> !adc_clk); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!active && !frame_stb) |=> !adc_clk); // R6
endmodule

// File: tb/readout_adcclk_dbg_test.sv
`timescale 1ns/1ps
module readout_adcclk_dbg_test;
  localparam int FRAME_LEN = 6;
  localparam int REF_SLOT  = 1;
  localparam int CELL_SLOT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_phase = 1'b0;
  logic frame_stb = 1'b0;
  logic [3:0] obs = 4'b0000;
  logic [1:0] dbg_sel = 2'd0;
  logic adc_clk, dbg_out;
  logic samp;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  readout_adcclk_dbg #(.FRAME_LEN(FRAME_LEN), .REF_SLOT(REF_SLOT), .CELL_SLOT(CELL_SLOT)) uut (
    .clk(clk), .rst(rst), .rd_phase(rd_phase), .frame_stb(frame_stb),
    .obs_last_row_rd(obs[0]), .obs_clk_sel(obs[1]), .obs_cell0_sel(obs[2]),
    .obs_clamp_cell0_sel(obs[3]), .dbg_sel(dbg_sel), .adc_clk(adc_clk), .dbg_out(dbg_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a negedge: drive, cross one rising edge, sample at next negedge.
  task automatic step(input logic stb, input logic rd);
    frame_stb = stb;
    rd_phase  = rd;
    @(posedge clk);
    @(negedge clk);
    samp = adc_clk;
  endtask

  function automatic logic exp_pulse(input int k);
    return (k == REF_SLOT + 1) || (k == CELL_SLOT + 1);
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 adc_clk in reset", adc_clk, 0);
    chk("R1 dbg_out in reset", dbg_out, 0);
    rst = 1'b0;
    step(1'b0, 1'b0);
    chk("R1 adc_clk after reset", adc_clk, 0);
    chk("R1 dbg_out after reset", dbg_out, 0);
  endtask

  task automatic t_readout_frame();
    for (int k = 0; k < FRAME_LEN; k++) begin
      step(k == 0, 1'b1);
      chk($sformatf("R2 slot %0d", k), samp, exp_pulse(k));
    end
  endtask

  task automatic t_write_frame();
    int rises = 0;
    logic prev = 1'b0;
    for (int k = 0; k < FRAME_LEN; k++) begin
      step(k == 0, 1'b0);
      if (samp && !prev) rises++;
      prev = samp;
    end
    chk("R3 write-phase edges", rises, 0);
  endtask

  task automatic t_pixel();
    int rises = 0;
    int idle_hi = 0;
    logic prev = 1'b0;
    for (int f = 0; f < 4; f++) begin
      for (int k = 0; k < FRAME_LEN; k++) begin
        step(k == 0, 1'b1);
        if (samp && !prev) rises++;
        prev = samp;
      end
    end
    chk("R4 edges per four-cell pixel", rises, 8);
    for (int k = 0; k < 2 * FRAME_LEN; k++) begin
      step(1'b0, 1'b1);
      if (samp) idle_hi++;
    end
    chk("R6 idle after frame", idle_hi, 0);
  endtask

  task automatic t_drop();
    for (int k = 0; k < FRAME_LEN; k++) begin
      step(k == 0, k < REF_SLOT + 2);
      if (k <= REF_SLOT + 1) chk($sformatf("R5 before drop slot %0d", k), samp, exp_pulse(k));
      else chk($sformatf("R5 after drop slot %0d", k), samp, 0);
    end
  endtask

  task automatic t_restart();
    int r = 3;
    for (int k = 0; k < r; k++) begin
      step(k == 0, 1'b1);
      chk($sformatf("R7 first frame slot %0d", k), samp, exp_pulse(k));
    end
    for (int k = 0; k < FRAME_LEN; k++) begin
      step(k == 0, 1'b1);
      chk($sformatf("R7 restarted slot %0d", k), samp, exp_pulse(k));
    end
  endtask

  task automatic t_dbg();
    for (int s = 0; s < 4; s++) begin
      obs = 4'b0001 << s;
      dbg_sel = 2'(s);
      step(1'b0, 1'b0);
      chk($sformatf("R8 sel %0d picks its source (one-hot)", s), dbg_out, 1);
      obs = ~(4'b0001 << s);
      step(1'b0, 1'b0);
      chk($sformatf("R8 sel %0d ignores other sources", s), dbg_out, 0);
    end
    obs = 4'b0101;
    dbg_sel = 2'd0;
    step(1'b0, 1'b0);
    chk("R9 settled value", dbg_out, 1);
    dbg_sel = 2'd1;
    #2;
    chk("R9 no change before edge", dbg_out, 1);
    @(posedge clk);
    @(negedge clk);
    chk("R9 updates at edge", dbg_out, 0);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_readout_frame();
    t_write_frame();
    t_pixel();
    t_drop();
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    t_restart();
    t_dbg();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule